// File: doc/BRIEF.md
# Triangular Lyapunov Equation Solver

This block finds the matrix X that satisfies AX + XB = C. A is an N×N lower-triangular matrix, B is an N×N upper-triangular matrix, and N is fixed when the block is compiled. All values are signed fixed-point numbers with 8 integer bits and 8 fraction bits, carried in 16-bit words. A host first streams the three operands in over a valid/ready input. It then pulses `start`. The block solves every unknown in turn and pulses `done`. After that it streams X back out over a valid/ready output.

Each unknown is the right-hand entry minus two triangular dot products, one taken over the solved entries above it in its column and one over the solved entries to its left in its row. That difference is divided by the sum of the matching diagonal entries of A and B. Entries that share the same value of row+column do not depend on each other. The controller therefore walks the matrix one anti-diagonal wavefront at a time, so every operand an entry needs is already final when that entry starts. A single rounding multiply-accumulate and a restoring divider handle the arithmetic. A zero denominator does not stop the run. The block raises an error flag, writes zero for that entry and carries on.

Top module: `lts_top`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid`, `done` and `err` are 0.
- R2: While `in_ready` is 1, each accepted input word goes to the next position in the order: all of A, then all of B, then all of C, each matrix in row-major order, so 3·N² words form one load. Words for A entries above the diagonal and for B entries below the diagonal are dropped and have no effect on X.
- R3: Entry (i,j) is set to (c[i][j] − Σ_{k<i} p(a[i][k],x[k][j]) − Σ_{l<j} p(b[l][j],x[i][l])) / (a[i][i] + b[j][j]). Here p(u,v) = (u·v + 128) >> 8, using an arithmetic shift, and the running sum wraps at 24 bits. The quotient is (|numerator|·256) / |denominator| truncated toward zero, and it is negative when exactly one of the two operands is negative.
- R4: Each accepted `start` produces exactly one `done` pulse, one cycle wide, after all N² entries have been written.
- R5: When a[i][i] + b[j][j] equals 0, `err` becomes 1, x[i][j] is set to 0 and the solve goes on. `err` stays set until the next accepted `start` clears it.
- R6: From an accepted `start` until the last output word has been taken, `in_ready` is 0. Any further `start` and any input words in that time are ignored.
- R7: When `done` pulses, `out_valid` rises and stays high. X is delivered in row-major order, one word per cycle in which `out_ready` is 1. A word is held stable while `out_ready` is 0. After the N²-th word the block is idle again, with `in_ready` = 1 and `out_valid` = 0.
- R8: A quotient magnitude above 32767 is limited to 32767, so the result is +32767 or −32767 depending on its sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand word valid |
| in_ready | output | 1 | Block accepts operand words and `start` (idle) |
| in_data | input | 16 | Operand word, signed Q8.8 |
| start | input | 1 | Begin solving with the loaded operands |
| done | output | 1 | One-cycle pulse when all of X is written |
| err | output | 1 | A zero denominator was met during the last solve |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | 16 | Result word x[i][j], signed Q8.8 |

## Verification
A wrong scheduling order, or a wrong accumulator term, makes the block read an unknown that has not been solved yet. The error then spreads along that row and column, so it shows up as wrong words in the very next readout of X. Each output word is compared with a bit-exact fixed-point model, so the first entry that differs is reported by its row and column. A divider or state-machine fault shows up instead as a missing or repeated `done`, or as a readout that never ends, all within one solve. Errors in the zero-denominator path and the saturation path show at once in the `err` flag and in the specific entries those tests set up.

// File: rtl/lts_pkg.sv
package lts_pkg;

  // Top-level controller phases.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_DIV  = 2'd2,
    ST_READ = 2'd3
  } lts_state_e;

endpackage

// File: rtl/lts_rst_sync.sv
module lts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  // Assert at once, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lts_sched.sv
module lts_sched #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          step,
  output logic [CW-1:0] row,
  output logic [CW-1:0] col,
  output logic          last
);

  localparam logic [CW-1:0] DIM    = CW'(N);
  localparam logic [CW-1:0] TOP_IX = CW'(N - 1);
  localparam logic [CW-1:0] LAST_D = CW'(2 * N - 2);

  logic [CW-1:0] d_q, r_q, c_q;
  logic [CW-1:0] d_d, r_d, c_d;
  logic [CW-1:0] r_hi, d_nx, r_lo;

  // Largest row index on the current wavefront, first row on the next one.
  always_comb begin
    r_hi = (d_q < DIM) ? d_q : TOP_IX;
    d_nx = d_q + CW'(1);
    r_lo = (d_nx >= DIM) ? (d_nx - TOP_IX) : '0;
  end

  always_comb begin
    d_d = d_q;
    r_d = r_q;
    c_d = c_q;
    if (init) begin
      d_d = '0;
      r_d = '0;
      c_d = '0;
    end else if (step) begin
      if (r_q < r_hi) begin
        r_d = r_q + CW'(1);
        c_d = c_q - CW'(1);
      end else begin
        d_d = d_nx;
        r_d = r_lo;
        c_d = d_nx - r_lo;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      r_q <= '0;
      c_q <= '0;
    end else if (init || step) begin
      d_q <= d_d;
      r_q <= r_d;
      c_q <= c_d;
    end
  end

  assign row  = r_q;
  assign col  = c_q;
  assign last = (d_q == LAST_D);

endmodule

// File: rtl/lts_div.sv
module lts_div #(
  parameter int NUMW = 32,
  parameter int DENW = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [NUMW-1:0] num,
  input  logic [DENW-1:0] den,
  output logic            done,
  output logic [NUMW-1:0] quot
);

  localparam int CNTW = $clog2(NUMW + 1);

  logic [DENW-1:0] rem_q, rem_d, dsr_q, dsr_d;
  logic [NUMW-1:0] q_q, q_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            run_q, run_d, done_q, done_d;
  logic [DENW:0]   shifted, diff;
  logic            ge;

  // One restoring step per cycle: shift in the next dividend bit, trial subtract.
  always_comb begin
    shifted = {rem_q, q_q[NUMW-1]};
    diff    = shifted - {1'b0, dsr_q};
    ge      = (shifted >= {1'b0, dsr_q});
  end

  always_comb begin
    rem_d  = rem_q;
    dsr_d  = dsr_q;
    q_d    = q_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go) begin
      rem_d = '0;
      dsr_d = den;
      q_d   = num;
      cnt_d = CNTW'(NUMW);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = ge ? DENW'(diff) : DENW'(shifted);
      q_d   = {q_q[NUMW-2:0], ge};
      cnt_d = cnt_q - CNTW'(1);
      if (cnt_q == CNTW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dsr_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (go || run_q) begin
        rem_q <= rem_d;
        dsr_q <= dsr_d;
        q_q   <= q_d;
        cnt_q <= cnt_d;
        run_q <= run_d;
      end
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quot = q_q;

endmodule

// File: rtl/lts_top.sv
module lts_top
  import lts_pkg::*;
#(
  parameter int N    = 4,
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         start,
  output logic         done,
  output logic         err,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  localparam int NN   = N * N;
  localparam int CW   = $clog2(2 * N);
  localparam int AW   = $clog2(NN);
  localparam int PW   = AW + CW;
  localparam int ACCW = 2 * W - FRAC;
  localparam int NUMW = ACCW + FRAC;
  localparam int DENW = W + 1;

  localparam logic [CW-1:0]          TOP_IX  = CW'(N - 1);
  localparam logic [AW-1:0]          LAST_RD = AW'(NN - 1);
  localparam logic signed [2*W-1:0]  RND_K   = (2 * W)'(1) << (FRAC - 1);
  localparam logic [NUMW-1:0]        MAXQ    = NUMW'((1 << (W - 1)) - 1);

  function automatic logic [AW-1:0] ix(input logic [CW-1:0] r, input logic [CW-1:0] c);
    return AW'(PW'(r) * PW'(N) + PW'(c));
  endfunction

  // ---------------- reset, state, storage ----------------
  logic rst_s_n;
  lts_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  lts_state_e state_q, state_d;

  logic signed [W-1:0] a_m [NN];
  logic signed [W-1:0] b_m [NN];
  logic signed [W-1:0] c_m [NN];
  logic signed [W-1:0] x_m [NN];

  logic [1:0]    sec_q;
  logic [CW-1:0] lr_q, lc_q;
  logic          ld_fire;

  // ---------------- schedule ----------------
  logic [CW-1:0] row, col;
  logic          sch_last, sch_init, sch_step;

  // ---------------- datapath ----------------
  logic [CW-1:0]         t_q, nterms, kidx, lidx;
  logic                  use_a;
  logic signed [W-1:0]   coef, xv, a_dg, b_dg;
  logic signed [2*W-1:0] prod;
  logic signed [ACCW-1:0] acc_q, term, c_ext;
  logic signed [DENW-1:0] den;
  logic                  den_zero;
  logic [ACCW-1:0]       acc_mag;
  logic [DENW-1:0]       den_mag;
  logic                  fin, cell_done, div_go, div_done, neg_q;
  logic [NUMW-1:0]       quot;
  logic [W-1:0]          q_sat;
  logic signed [W-1:0]   x_wdata;
  logic [AW-1:0]         rd_q;
  logic                  done_q, err_q, rd_fire;

  lts_sched #(.N(N), .CW(CW)) u_sched (
    .clk(clk), .rst_n(rst_s_n), .init(sch_init), .step(sch_step),
    .row(row), .col(col), .last(sch_last)
  );

  lts_div #(.NUMW(NUMW), .DENW(DENW)) u_div (
    .clk(clk), .rst_n(rst_s_n), .go(div_go),
    .num({acc_mag, FRAC'(0)}), .den(den_mag),
    .done(div_done), .quot(quot)
  );

  // Term selection: step t (1..nterms) uses column term k=t-1 while k<row,
  // then row term l=k-row.
  always_comb begin
    nterms = row + col;
    kidx   = t_q - CW'(1);
    lidx   = kidx - row;
    use_a  = (kidx < row);
    coef   = use_a ? a_m[ix(row, kidx)] : b_m[ix(lidx, col)];
    xv     = use_a ? x_m[ix(kidx, col)] : x_m[ix(row, lidx)];
    prod   = coef * xv;
    term   = ACCW'((prod + RND_K) >>> FRAC);
    c_ext  = ACCW'(c_m[ix(row, col)]);
    a_dg   = a_m[ix(row, row)];
    b_dg   = b_m[ix(col, col)];
    den    = DENW'(a_dg) + DENW'(b_dg);
    den_zero = (den == '0);
    acc_mag  = acc_q[ACCW-1] ? ACCW'(-acc_q) : ACCW'(acc_q);
    den_mag  = den[DENW-1] ? DENW'(-den) : DENW'(den);
    q_sat    = (quot > MAXQ) ? W'(MAXQ) : W'(quot);
  end

  always_comb begin
    ld_fire   = in_valid && in_ready;
    rd_fire   = out_valid && out_ready;
    fin       = (state_q == ST_MAC) && (t_q > nterms);
    div_go    = fin && !den_zero;
    cell_done = (fin && den_zero) || ((state_q == ST_DIV) && div_done);
    sch_init  = (state_q == ST_IDLE) && start;
    sch_step  = cell_done && !sch_last;
    if (state_q == ST_DIV) x_wdata = neg_q ? -$signed(q_sat) : $signed(q_sat);
    else                   x_wdata = '0;
  end

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_MAC;
      ST_MAC: begin
        if (div_go)                     state_d = ST_DIV;
        else if (cell_done && sch_last) state_d = ST_READ;
      end
      ST_DIV: begin
        if (div_done) state_d = sch_last ? ST_READ : ST_MAC;
      end
      ST_READ: if (rd_fire && (rd_q == LAST_RD)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- control registers ----------------
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      sec_q   <= '0;
      lr_q    <= '0;
      lc_q    <= '0;
      t_q     <= '0;
      acc_q   <= '0;
      neg_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      if (ld_fire) begin
        lc_q <= (lc_q == TOP_IX) ? '0 : lc_q + CW'(1);
        if (lc_q == TOP_IX) begin
          lr_q <= (lr_q == TOP_IX) ? '0 : lr_q + CW'(1);
          if (lr_q == TOP_IX) sec_q <= (sec_q == 2'd2) ? 2'd0 : sec_q + 2'd1;
        end
      end
      if (sch_init || sch_step)                t_q <= '0;
      else if ((state_q == ST_MAC) && !fin)    t_q <= t_q + CW'(1);
      if ((state_q == ST_MAC) && (t_q == '0))  acc_q <= c_ext;
      else if ((state_q == ST_MAC) && !fin)    acc_q <= acc_q - term;
      if (div_go) neg_q <= acc_q[ACCW-1] ^ den[DENW-1];
      if (sch_init)                 err_q <= 1'b0;
      else if (fin && den_zero)     err_q <= 1'b1;
      done_q <= cell_done && sch_last;
      if (cell_done && sch_last)    rd_q <= '0;
      else if (rd_fire)             rd_q <= rd_q + AW'(1);
    end
  end

  // ---------------- operand and result storage ----------------
  always_ff @(posedge clk) begin
    if (ld_fire) begin
      unique case (sec_q)
        2'd0:    if (lc_q <= lr_q) a_m[ix(lr_q, lc_q)] <= $signed(in_data);
        2'd1:    if (lc_q >= lr_q) b_m[ix(lr_q, lc_q)] <= $signed(in_data);
        default: c_m[ix(lr_q, lc_q)] <= $signed(in_data);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cell_done) x_m[ix(row, col)] <= x_wdata;
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_READ);
  assign out_data  = x_m[rd_q];
  assign done      = done_q;
  assign err       = err_q;

endmodule

// File: rtl/lts_sva.sv
module lts_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         start,
  input logic         done,
  input logic         err,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4

  AST_DONE_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n) done |-> out_valid); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !in_ready); // R6

  AST_ERR_RISES_IN_SOLVE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> !in_ready); // R5

  AST_ERR_CLEARED_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in_ready) |=> !err); // R5

endmodule

bind lts_top lts_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .start(start), .done(done),
  .err(err), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/lts_top_tb_top.sv
module lts_top_tb_top;

  localparam int N = 4;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         start = 1'b0;
  logic         done, err, out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;

  always #2 clk = ~clk;

  lts_top #(.N(N), .W(W), .FRAC(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .start(start), .done(done), .err(err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int am [N][N];
  int bm [N][N];
  int cm [N][N];
  int xm [N][N];
  bit merr;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint wrap24(input longint v);
    longint r;
    r = v & 64'hFFFFFF;
    if (r >= 64'h800000) r = r - 64'h1000000;
    return r;
  endfunction

  function automatic longint rprod(input int u, input int v);
    longint p;
    p = longint'(u) * longint'(v);
    p = (p + 128) >>> 8;
    return wrap24(p);
  endfunction

  // Fixed-point model of the recurrence; row-major order respects all dependencies.
  function automatic void model();
    merr = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        longint acc, den, mag, q;
        acc = cm[i][j];
        for (int k = 0; k < i; k++) acc = wrap24(acc - rprod(am[i][k], xm[k][j]));
        for (int l = 0; l < j; l++) acc = wrap24(acc - rprod(bm[l][j], xm[i][l]));
        den = am[i][i] + bm[j][j];
        if (den == 0) begin
          xm[i][j] = 0;
          merr = 1'b1;
        end else begin
          mag = (acc < 0) ? -acc : acc;
          q = (mag * 256) / ((den < 0) ? -den : den);
          if (q > 32767) q = 32767;
          xm[i][j] = int'(((acc < 0) != (den < 0)) ? -q : q);
        end
      end
    end
  endfunction

  function automatic int srand(input int lo, input int hi);
    return lo + int'($urandom_range(hi - lo));
  endfunction

  function automatic void fill_random(input bit garbage);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i == j) begin
          am[i][j] = srand(256, 512);
          bm[i][j] = srand(256, 512);
        end else if (j < i) begin
          am[i][j] = srand(-64, 64);
          bm[i][j] = garbage ? srand(-20000, 20000) : 0;
        end else begin
          am[i][j] = garbage ? srand(-20000, 20000) : 0;
          bm[i][j] = srand(-64, 64);
        end
        cm[i][j] = srand(-1024, 1024);
      end
    end
  endfunction

  task automatic send_word(input int v);
    in_valid = 1'b1;
    in_data  = W'(v);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load_all();
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) send_word(am[r][c]);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) send_word(bm[r][c]);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) send_word(cm[r][c]);
  endtask

  // Start a solve; optionally poke start and a junk word while busy.
  task automatic run_solve(input int poke_at);
    int ndone;
    int cyc;
    ndone = 0;
    cyc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (ndone == 0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke_at) begin
        chk(in_ready == 1'b0, "R6", "in_ready while solving", int'(in_ready), 0);
        start    = 1'b1;
        in_valid = 1'b1;
        in_data  = 16'h7FFF;
      end else begin
        start    = 1'b0;
        in_valid = 1'b0;
      end
      if (done) ndone++;
    end
    start = 1'b0;
    in_valid = 1'b0;
    chk(ndone == 1, "R4", "done pulse seen", ndone, 1);
  endtask

  task automatic read_check(input int mode, input string req);
    int got;
    int cyc;
    got = 0;
    cyc = 0;
    while (got < N * N && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (done) chk(1'b0, "R4", "extra done pulse", 1, 0);
      if (mode == 0)      out_ready = 1'b1;
      else if (mode == 1) out_ready = cyc[0];
      else                out_ready = (cyc % 3) != 0;
      if (out_valid && out_ready) begin
        chk(out_data == W'(xm[got / N][got % N]), req,
            $sformatf("x[%0d][%0d]", got / N, got % N),
            int'($signed(out_data)), xm[got / N][got % N]);
        got++;
      end
    end
    chk(got == N * N, "R7", "words read", got, N * N);
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R7", "idle after readout", int'(in_ready), 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(err == 1'b0, "R1", "err after reset", int'(err), 0);
  endtask

  task automatic t_identity();
    // A = B = I with large junk in the dropped triangles: x = c/2 exactly.
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        am[i][j] = (i == j) ? 256 : ((j > i) ? 30000 : 0);
        bm[i][j] = (i == j) ? 256 : ((j < i) ? -30000 : 0);
        cm[i][j] = srand(-2000, 2000);
      end
    end
    model();
    load_all();
    run_solve(0);
    chk(err == 1'b0, "R2", "err with identity", int'(err), 0);
    read_check(0, "R2");
  endtask

  task automatic t_random(input int mode);
    fill_random(1'b1);
    model();
    load_all();
    run_solve(0);
    chk(err == 1'b0, "R3", "err with regular operands", int'(err), 0);
    read_check(mode, "R3");
  endtask

  task automatic t_zero_den();
    fill_random(1'b0);
    for (int i = 0; i < N; i++) begin
      am[i][i] = 384;
      bm[i][i] = 384;
    end
    am[1][1] = 256;
    bm[2][2] = -256;
    model();
    load_all();
    run_solve(0);
    chk(err == 1'b1 && merr, "R5", "err after zero denominator", int'(err), 1);
    chk(xm[1][2] == 0, "R5", "model x[1][2]", xm[1][2], 0);
    read_check(0, "R5");
    // A following clean solve clears the flag.
    fill_random(1'b0);
    model();
    load_all();
    run_solve(0);
    chk(err == 1'b0, "R5", "err cleared by next start", int'(err), 0);
    read_check(0, "R5");
  endtask

  task automatic t_busy_start();
    fill_random(1'b1);
    model();
    load_all();
    run_solve(25);
    read_check(1, "R6");
  endtask

  task automatic t_saturate(input int cval, input int expv);
    fill_random(1'b0);
    am[0][0] = 1;
    bm[0][0] = 1;
    cm[0][0] = cval;
    model();
    chk(xm[0][0] == expv, "R8", "model saturation", xm[0][0], expv);
    load_all();
    run_solve(0);
    @(negedge clk);
    out_ready = 1'b1;
    chk(out_valid == 1'b1 && $signed(out_data) == W'(expv), "R8", "saturated x[0][0]",
        int'($signed(out_data)), expv);
    out_ready = 1'b0;
    read_check(2, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_identity();
    t_random(0);
    t_random(1);
    t_random(2);
    t_zero_den();
    t_busy_start();
    t_saturate(25600, 32767);
    t_saturate(-25600, -32767);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule